// File: doc/BRIEF.md
# Binary Hit Output Conditioner

This block is the digital back end of a bank of per-channel threshold comparators in a front-end that runs on a beam-synchronous clock. It takes the raw comparator decisions, corrects them for the selected input-signal polarity and registers them on the bunch clock. It then turns each registered decision into a hit bit. Two output styles are offered. In time-over-threshold style the hit is high for every clock bin in which the signal sits above threshold. In single-pulse style the hit is high for one clock per threshold crossing.

The hit bits feed two consumers. A fast trigger path receives the OR of every group of four adjacent channels. The storage pipeline receives one code per channel. That code is either the analog sample passed straight through, or, when binary storage is chosen, a configurable large-amplitude code for a hit and a pedestal code for no hit.

Top module: `hit_conditioner`

## Requirements
- R1: While reset is asserted, and after its release until the first rising edge, every bit of hitOut and groupOr is 0.
- R2: Each channel's decision is rawHit[i] XOR polarityNeg, sampled at a rising clock edge. It appears on hitOut one edge later and is held until the next edge. The group and pipeline outputs follow hitOut with no further register.
- R3: With pulseMode = 0 (time-over-threshold), hitOut[i] is high in every clock cycle whose registered decision is high, including runs of several consecutive cycles.
- R4: With pulseMode = 1 (single pulse), hitOut[i] is high for exactly one cycle when the registered decision goes from low to high. A decision that stays high gives no further pulse, and a new pulse requires the decision to be low for at least one cycle first.
- R5: polarityNeg = 0 treats rawHit = 1 as over threshold. polarityNeg = 1 treats rawHit = 0 as over threshold. In both cases hitOut is active high.
- R6: A change of pulseMode or polarityNeg takes effect at the next rising edge and clears the crossing history. In pulse mode, a decision that is high in the first cycle after the change therefore produces one pulse.
- R7: groupOr[g] is the OR of hitOut[4g], hitOut[4g+1], hitOut[4g+2] and hitOut[4g+3].
- R8: With binSource = 1, lane i of pipeCode (bits 8i+7 down to 8i) equals hitCode when hitOut[i] = 1 and pedCode when hitOut[i] = 0.
- R9: With binSource = 0, lane i of pipeCode equals lane i of analogSample, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-synchronous bunch clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rawHit | input | NUM_CH | Raw comparator decisions, one per channel |
| polarityNeg | input | 1 | 1 selects negative-going input signals |
| pulseMode | input | 1 | 0 time-over-threshold, 1 single pulse per crossing |
| binSource | input | 1 | 1 stores binary hit codes, 0 stores analog samples |
| hitCode | input | CODE_W | Code written for a hit in binary storage |
| pedCode | input | CODE_W | Pedestal code written for no hit |
| analogSample | input | NUM_CH*CODE_W | Digitised shaper samples, lane i at bits CODE_W*i |
| hitOut | output | NUM_CH | Conditioned active-high hit bits |
| groupOr | output | NUM_CH/4 | OR of each group of four neighbouring hits |
| pipeCode | output | NUM_CH*CODE_W | Per-channel code sent to the storage pipeline |

## Verification
The bench targets long over-threshold runs. A design that only marks the first bin would drop the tail in time-over-threshold style, and one that forgets the edge history would repeat pulses in single-pulse style. It flips polarity and mode while decisions are held high. A design that ignores the change until a later edge, or keeps the stale history, would miss the one pulse it owes or produce an extra one. It also drives single hits into each position of a group and switches the storage source every cycle, so that a wrong group boundary, a swapped hit and pedestal code, or a stray register on the pipeline path shows up as a wrong lane value.

// File: rtl/hit_pkg.sv
package hit_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic polInv;     // invert raw decisions before registration
    logic pulseSel;   // registered output-style select
    logic clearHist;  // wipe crossing history at this edge
  } ctrl_t;
endpackage

// File: rtl/hit_ctrl.sv
module hit_ctrl
  import hit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  polarityNeg,
  input  logic  pulseMode,
  output ctrl_t ctrl
);
  logic polQ;
  logic modeQ;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polQ  <= 1'b0;
      modeQ <= 1'b0;
      live  <= 1'b0;
    end else begin
      polQ  <= polarityNeg;
      modeQ <= pulseMode;
      live  <= 1'b1;
    end
  end

  always_comb begin
    ctrl.polInv    = polarityNeg;
    ctrl.pulseSel  = modeQ;
    ctrl.clearHist = (polarityNeg != polQ) || (pulseMode != modeQ);
  end

  // R6: the style select in use is the one sampled at the previous edge
  a_r6_mode_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (ctrl.pulseSel == $past(pulseMode)));

endmodule

// File: rtl/hit_path.sv
module hit_path
  import hit_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 8,
  parameter int GRP    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  logic [NUM_CH-1:0]        rawHit,
  input  logic                     binSource,
  input  logic [CODE_W-1:0]        hitCode,
  input  logic [CODE_W-1:0]        pedCode,
  input  logic [NUM_CH*CODE_W-1:0] analogSample,
  output logic [NUM_CH-1:0]        hitOut,
  output logic [NUM_CH/GRP-1:0]    groupOr,
  output logic [NUM_CH*CODE_W-1:0] pipeCode
);
  localparam int NUM_GRP = NUM_CH / GRP;

  logic [NUM_CH-1:0] decReg;
  logic [NUM_CH-1:0] prevDec;
  logic              live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        decReg[ch]  <= 1'b0;
        prevDec[ch] <= 1'b0;
      end else begin
        decReg[ch]  <= rawHit[ch] ^ ctrl.polInv;
        prevDec[ch] <= ctrl.clearHist ? 1'b0 : decReg[ch];
      end
    end

    assign hitOut[ch] = ctrl.pulseSel ? (decReg[ch] & ~prevDec[ch]) : decReg[ch];

    assign pipeCode[ch*CODE_W +: CODE_W] =
      binSource ? (hitOut[ch] ? hitCode : pedCode)
                : analogSample[ch*CODE_W +: CODE_W];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
    assign groupOr[g] = |hitOut[g*GRP +: GRP];
  end

  // R4: without a history wipe, no channel pulses in two consecutive cycles
  a_r4_no_double_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctrl.pulseSel && !$past(ctrl.clearHist)) |-> ((hitOut & $past(hitOut)) == '0));

  // R7: a group bit can only be set if some channel is set
  a_r7_group_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(groupOr) <= $countones(hitOut));

endmodule

// File: rtl/hit_conditioner.sv
module hit_conditioner
  import hit_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        rawHit,
  input  logic                     polarityNeg,
  input  logic                     pulseMode,
  input  logic                     binSource,
  input  logic [CODE_W-1:0]        hitCode,
  input  logic [CODE_W-1:0]        pedCode,
  input  logic [NUM_CH*CODE_W-1:0] analogSample,
  output logic [NUM_CH-1:0]        hitOut,
  output logic [NUM_CH/4-1:0]      groupOr,
  output logic [NUM_CH*CODE_W-1:0] pipeCode
);
  localparam int GRP = 4;

  ctrl_t ctrl;
  logic  live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  hit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .polarityNeg (polarityNeg),
    .pulseMode   (pulseMode),
    .ctrl        (ctrl)
  );

  hit_path #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .GRP    (GRP)
  ) u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .rawHit       (rawHit),
    .binSource    (binSource),
    .hitCode      (hitCode),
    .pedCode      (pedCode),
    .analogSample (analogSample),
    .hitOut       (hitOut),
    .groupOr      (groupOr),
    .pipeCode     (pipeCode)
  );

  // R2 R3 R5: in time-over-threshold style the output is last edge's corrected decision
  a_r3_tot_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(pulseMode)) |->
      (hitOut == ($past(rawHit) ^ {NUM_CH{$past(polarityNeg)}})));

  // R8: binary storage with no hits shows the pedestal code on every lane
  a_r8_pedestal_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (binSource && hitOut == '0) |-> (pipeCode == {NUM_CH{pedCode}}));

endmodule

// File: tb/hit_conditioner_bench.sv
module hit_conditioner_bench;
  localparam int NUM_CH = 8;
  localparam int CODE_W = 8;
  localparam int NG     = NUM_CH / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0]        rawHit = '0;
  logic                     polarityNeg = 1'b0;
  logic                     pulseMode = 1'b0;
  logic                     binSource = 1'b0;
  logic [CODE_W-1:0]        hitCode = 8'hC8;
  logic [CODE_W-1:0]        pedCode = 8'h10;
  logic [NUM_CH*CODE_W-1:0] analogSample = '0;
  logic [NUM_CH-1:0]        hitOut;
  logic [NG-1:0]            groupOr;
  logic [NUM_CH*CODE_W-1:0] pipeCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [NUM_CH-1:0] mDec = '0, mPrev = '0;
  logic mPol = 1'b0, mMode = 1'b0;

  always #2 clk = ~clk;

  hit_conditioner #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_hit_conditioner (
    .clk(clk), .rst_n(rst_n), .rawHit(rawHit), .polarityNeg(polarityNeg),
    .pulseMode(pulseMode), .binSource(binSource), .hitCode(hitCode),
    .pedCode(pedCode), .analogSample(analogSample), .hitOut(hitOut),
    .groupOr(groupOr), .pipeCode(pipeCode));

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] expHit();
    return mMode ? (mDec & ~mPrev) : mDec;
  endfunction

  function automatic logic [NG-1:0] expGroup(input logic [NUM_CH-1:0] h);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |h[g*4 +: 4];
    return r;
  endfunction

  function automatic logic [NUM_CH*CODE_W-1:0] expPipe(input logic [NUM_CH-1:0] h);
    logic [NUM_CH*CODE_W-1:0] r;
    for (int i = 0; i < NUM_CH; i++)
      r[i*CODE_W +: CODE_W] = binSource ? (h[i] ? hitCode : pedCode)
                                        : analogSample[i*CODE_W +: CODE_W];
    return r;
  endfunction

  // called at a falling edge: drive, clock, update model, check
  task automatic step(input logic [NUM_CH-1:0] raw, input logic pol,
                      input logic mode, input logic bsrc, input string tag);
    logic [NUM_CH-1:0] h;
    logic chg;
    rawHit = raw; polarityNeg = pol; pulseMode = mode; binSource = bsrc;
    analogSample = {$urandom, $urandom};
    @(posedge clk);
    chg   = (pol != mPol) || (mode != mMode);
    mPrev = chg ? '0 : mDec;
    mDec  = raw ^ {NUM_CH{pol}};
    mPol  = pol;
    mMode = mode;
    @(negedge clk);
    h = expHit();
    check(tag, "hitOut", 64'(hitOut), 64'(h));
    check("R7", "groupOr", 64'(groupOr), 64'(expGroup(h)));
    check(bsrc ? "R8" : "R9", "pipeCode", pipeCode, expPipe(h));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rawHit = '1;
    repeat (3) @(negedge clk);
    check("R1", "hitOut in reset", 64'(hitOut), 64'h0);
    check("R1", "groupOr in reset", 64'(groupOr), 64'h0);
    rst_n = 1'b1;
    #1;
    check("R1", "hitOut after release", 64'(hitOut), 64'h0);
    @(negedge clk);

    // R2/R3: time-over-threshold, multi-bin run on channel 2, single bin on 5
    step(8'h04, 0, 0, 0, "R2");
    step(8'h24, 0, 0, 1, "R3");
    step(8'h04, 0, 0, 1, "R3");
    step(8'h04, 0, 0, 0, "R3");
    step(8'h00, 0, 0, 1, "R3");

    // R7: one hit in each position of each group
    for (int i = 0; i < NUM_CH; i++) step(8'(1 << i), 0, 0, 1, "R7");

    // R4: pulse mode, held high gives one pulse, re-arm after a low cycle
    step(8'h00, 0, 1, 1, "R4");
    step(8'h81, 0, 1, 1, "R4");
    step(8'h81, 0, 1, 1, "R4");
    step(8'h81, 0, 1, 0, "R4");
    step(8'h01, 0, 1, 1, "R4");
    step(8'h80, 0, 1, 1, "R4");
    step(8'h81, 0, 1, 1, "R4");

    // R5: negative polarity, raw low means over threshold
    step(8'hFF, 1, 0, 1, "R5");
    step(8'hF0, 1, 0, 1, "R5");
    step(8'hFE, 1, 0, 0, "R5");

    // R6: mode change while decision held high produces one pulse
    step(8'h01, 0, 0, 1, "R6");
    step(8'h01, 0, 0, 1, "R6");
    step(8'h01, 0, 1, 1, "R6");
    step(8'h01, 0, 1, 1, "R6");
    // R6: polarity flip in pulse mode with decision high after flip
    step(8'h00, 1, 1, 1, "R6");
    step(8'h00, 1, 1, 1, "R6");

    // random phase; mode and polarity change rarely
    for (int n = 0; n < 3000; n++) begin
      logic p, m;
      p = (($urandom % 16) == 0) ? ~polarityNeg : polarityNeg;
      m = (($urandom % 16) == 0) ? ~pulseMode : pulseMode;
      step(8'($urandom), p, m, 1'($urandom), m ? "R4" : "R3");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule